// File: doc/BRIEF.md
# Two-Line Prioritized Interrupt Vector Controller

This block takes a set of asynchronous interrupt request lines from peripherals and turns each rising edge into a single-bit pending flag. Every source has an enable bit, a 4-bit priority, a handler address and a route bit. The route bit places the source on either the normal request line or the fast request line. Among the sources that are pending and enabled, the controller picks a winner and shows that source's number and handler address to the processor, so software can branch straight to the handler.

The fast line always outranks the normal line when the vector is chosen. Software clears a serviced source by pulsing the acknowledge input with that source's number. Pending flags do not count events, so a new edge on a source that is already pending is lost. A simple write-only configuration port loads the enables, the route bits, the priorities, the handler addresses and a default address. The default address is shown whenever nothing is eligible.

Top module: `vic_top`

## Requirements
- R1: After reset, irqReq and fiqReq are low, vecSrc is 0 and vecAddr is 0, because all enables, route bits, priorities, handler addresses and the default address reset to zero.
- R2: A rising edge on reqIn[i] passes through a two-flop synchronizer and an edge detector. It becomes visible at the outputs after the third rising clock edge following the input change, and not after the second. A level held high sets the pending flag only once.
- R3: A pending source whose enable bit is 0 drives neither request line. Its pending flag is still kept, and it requests as soon as it is enabled.
- R4: Among eligible sources on the same line, the one with the numerically largest priority is presented.
- R5: When eligible sources have equal priority, the lower source index wins.
- R6: A pending flag stays set, and its request stays asserted, until ackValid is high with ackSrc equal to that source. That acknowledge clears the flag on the clock edge.
- R7: A second rising edge on a source that is already pending is dropped, so one acknowledge leaves the source idle.
- R8: A source whose route bit is 1 raises fiqReq and not irqReq. A source whose route bit is 0 raises irqReq and not fiqReq.
- R9: If any fast-routed source is eligible, the vector shows the fast winner, whatever the priorities of normal sources. irqReq still reflects the eligible normal sources.
- R10: vecSrc carries the winner's index and vecAddr carries the handler address configured for that index.
- R11: With no eligible source, both request lines are low and vecAddr equals the programmed default address.
- R12: If a new edge and an acknowledge reach the same source in the same cycle, the pending flag stays set.
- R13: Configuration writes with cfgWe high use these addresses. 0x00 is the enable mask (bit i is source i). 0x01 is the route mask (bit i is 1 for the fast line). 0x02 is the default address. 0x10+i is the priority of source i (low 4 bits). 0x20+i is the handler address of source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | NUM_SRC | Raw peripheral request lines, asynchronous |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration register address |
| cfgWdata | input | ADDR_W | Configuration write data |
| ackValid | input | 1 | Acknowledge strobe |
| ackSrc | input | IDX_W | Source number being acknowledged |
| irqReq | output | 1 | Normal processor request |
| fiqReq | output | 1 | Fast processor request |
| vecAddr | output | ADDR_W | Handler address of the winner, or the default address |
| vecSrc | output | IDX_W | Index of the winning source, 0 when idle |

## Verification
The selection logic is tried with three kinds of input. Two normal sources with different priorities show whether the largest priority wins, and acknowledging the winner shows whether the runner-up then takes over. Two sources with equal priority show whether ties go to the lower index. A low-priority fast source set against a high-priority normal source shows whether the line ordering is applied before the priority comparison. Other patterns target the pending flag itself: repeated edges, a held level, a disabled source, and an edge that lands in the same cycle as its acknowledge. These separate edge detection from level sensing, and they show whether set or clear takes precedence.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef struct packed {
    logic enWr;
    logic fastWr;
    logic dfltWr;
    logic prioWr;
    logic handlerWr;
  } cfgStrobe_t;

  localparam logic [1:0] REGION_CTRL    = 2'd0;
  localparam logic [1:0] REGION_PRIO    = 2'd1;
  localparam logic [1:0] REGION_HANDLER = 2'd2;
  localparam logic [3:0] SLOT_EN   = 4'd0;
  localparam logic [3:0] SLOT_FAST = 4'd1;
  localparam logic [3:0] SLOT_DFLT = 4'd2;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int CFG_AW  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic               ackValid,
  input  logic [IDX_W-1:0]   ackSrc,
  output cfgStrobe_t         strobe,
  output logic [IDX_W-1:0]   cfgIdx,
  output logic [NUM_SRC-1:0] setMask,
  output logic [NUM_SRC-1:0] clrMask
);
  logic [NUM_SRC-1:0] syncA, syncB, syncC;
  logic [1:0] region;
  logic [3:0] slot;
  logic slotOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= reqIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign setMask = syncB & ~syncC;

  always_comb begin
    clrMask = '0;
    if (ackValid && ({1'b0, ackSrc} < (IDX_W+1)'(NUM_SRC)))
      clrMask = NUM_SRC'(1) << ackSrc;
  end

  assign region = cfgAddr[5:4];
  assign slot   = cfgAddr[3:0];
  assign slotOk = ({1'b0, slot} < 5'(NUM_SRC));
  assign cfgIdx = slot[IDX_W-1:0];

  always_comb begin
    strobe = '0;
    if (cfgWe) begin
      strobe.enWr      = (region == REGION_CTRL) && (slot == SLOT_EN);
      strobe.fastWr    = (region == REGION_CTRL) && (slot == SLOT_FAST);
      strobe.dfltWr    = (region == REGION_CTRL) && (slot == SLOT_DFLT);
      strobe.prioWr    = (region == REGION_PRIO) && slotOk;
      strobe.handlerWr = (region == REGION_HANDLER) && slotOk;
    end
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]             active,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab,
  output logic                           hit,
  output logic [IDX_W-1:0]               winIdx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    hit    = 1'b0;
    winIdx = '0;
    best   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i] && (!hit || prioTab[i] > best)) begin
        hit    = 1'b1;
        winIdx = IDX_W'(i);
        best   = prioTab[i];
      end
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [ADDR_W-1:0]  cfgWdata,
  input  logic [NUM_SRC-1:0] setMask,
  input  logic [NUM_SRC-1:0] clrMask,
  output logic               irqReq,
  output logic               fiqReq,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [IDX_W-1:0]   vecSrc,
  output logic [NUM_SRC-1:0] pendBits,
  output logic [NUM_SRC-1:0] enBits,
  output logic [NUM_SRC-1:0] fastBits,
  output logic [ADDR_W-1:0]  dfltAddr
);
  localparam int LINES = 2;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prioTab;
  logic [NUM_SRC-1:0][ADDR_W-1:0] handlerTab;
  logic [LINES-1:0][NUM_SRC-1:0]  lineActive;
  logic [LINES-1:0]               lineHit;
  logic [LINES-1:0][IDX_W-1:0]    lineIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendBits   <= '0;
      enBits     <= '0;
      fastBits   <= '0;
      dfltAddr   <= '0;
      prioTab    <= '0;
      handlerTab <= '0;
    end else begin
      pendBits <= (pendBits & ~clrMask) | setMask;
      if (strobe.enWr)      enBits   <= cfgWdata[NUM_SRC-1:0];
      if (strobe.fastWr)    fastBits <= cfgWdata[NUM_SRC-1:0];
      if (strobe.dfltWr)    dfltAddr <= cfgWdata;
      if (strobe.prioWr)    prioTab[cfgIdx]    <= cfgWdata[PRIO_W-1:0];
      if (strobe.handlerWr) handlerTab[cfgIdx] <= cfgWdata;
    end
  end

  // line 0 = normal, line 1 = fast
  assign lineActive[0] = pendBits & enBits & ~fastBits;
  assign lineActive[1] = pendBits & enBits & fastBits;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    vic_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) uArb (
      .active (lineActive[g]),
      .prioTab(prioTab),
      .hit    (lineHit[g]),
      .winIdx (lineIdx[g])
    );
  end

  assign irqReq = lineHit[0];
  assign fiqReq = lineHit[1];

  always_comb begin
    if (lineHit[1]) begin
      vecSrc  = lineIdx[1];
      vecAddr = handlerTab[lineIdx[1]];
    end else if (lineHit[0]) begin
      vecSrc  = lineIdx[0];
      vecAddr = handlerTab[lineIdx[0]];
    end else begin
      vecSrc  = '0;
      vecAddr = dfltAddr;
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 6,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  cfgWdata,
  input  logic               ackValid,
  input  logic [IDX_W-1:0]   ackSrc,
  output logic               irqReq,
  output logic               fiqReq,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [IDX_W-1:0]   vecSrc
);
  cfgStrobe_t         strobe;
  logic [IDX_W-1:0]   cfgIdx;
  logic [NUM_SRC-1:0] setMask, clrMask;
  logic [NUM_SRC-1:0] pendBits, enBits, fastBits;
  logic [ADDR_W-1:0]  dfltAddr;

  vic_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CFG_AW(CFG_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .ackValid(ackValid), .ackSrc(ackSrc), .strobe(strobe), .cfgIdx(cfgIdx),
    .setMask(setMask), .clrMask(clrMask)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIdx(cfgIdx), .cfgWdata(cfgWdata),
    .setMask(setMask), .clrMask(clrMask), .irqReq(irqReq), .fiqReq(fiqReq),
    .vecAddr(vecAddr), .vecSrc(vecSrc), .pendBits(pendBits), .enBits(enBits),
    .fastBits(fastBits), .dfltAddr(dfltAddr)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               ackValid,
  input logic               irqReq,
  input logic               fiqReq,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [IDX_W-1:0]   vecSrc,
  input logic [NUM_SRC-1:0] pendBits,
  input logic [NUM_SRC-1:0] enBits,
  input logic [NUM_SRC-1:0] fastBits,
  input logic [ADDR_W-1:0]  dfltAddr
);
  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> ((pendBits & $past(pendBits)) == $past(pendBits)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendBits & enBits) == '0) |-> (!irqReq && !fiqReq));

  // R8
  fast_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> ((pendBits & enBits & fastBits) != '0));

  // R9
  fast_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> (fastBits[vecSrc] && pendBits[vecSrc]));

  // R11
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && !fiqReq) |-> (vecAddr == dfltAddr));
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .ackValid(ackValid), .irqReq(irqReq), .fiqReq(fiqReq),
  .vecAddr(vecAddr), .vecSrc(vecSrc), .pendBits(pendBits), .enBits(enBits),
  .fastBits(fastBits), .dfltAddr(dfltAddr)
);

// File: tb/vic_top_test.sv
module vic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam logic [31:0] DFLT = 32'hDEAD0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic cfgWe = 1'b0;
  logic [5:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic ackValid = 1'b0;
  logic [2:0] ackSrc = '0;
  logic irqReq, fiqReq;
  logic [31:0] vecAddr;
  logic [2:0] vecSrc;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .ackValid(ackValid), .ackSrc(ackSrc), .irqReq(irqReq),
    .fiqReq(fiqReq), .vecAddr(vecAddr), .vecSrc(vecSrc)
  );

  function automatic logic [31:0] hAddr(int i);
    return 32'h1000 + 32'(i) * 32'h10;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectState(input string req, input bit irq, input bit fiq, input int src);
    check(irqReq == irq, {req, " irqReq"}, 32'(irqReq), 32'(irq));
    check(fiqReq == fiq, {req, " fiqReq"}, 32'(fiqReq), 32'(fiq));
    if (irq || fiq) begin
      check(vecSrc == 3'(src), {req, " vecSrc"}, 32'(vecSrc), 32'(src));
      check(vecAddr == hAddr(src), {req, " vecAddr"}, vecAddr, hAddr(src));
    end else begin
      check(vecAddr == DFLT, {req, " default vecAddr"}, vecAddr, DFLT);
    end
  endtask

  task automatic cfgWrite(input logic [5:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic ack(input int s);
    ackValid = 1'b1; ackSrc = 3'(s);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic pulse(input int s);
    reqIn[s] = 1'b1;
    repeat (3) @(negedge clk);
    reqIn[s] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    // R1
    check(!irqReq && !fiqReq, "R1 requests", {30'd0, irqReq, fiqReq}, 0);
    check(vecSrc == 0, "R1 vecSrc", 32'(vecSrc), 0);
    check(vecAddr == 0, "R1 vecAddr", vecAddr, 0);
  endtask

  task automatic testConfigIdle();
    // R13 setup, R11 idle default
    for (int i = 0; i < N; i++) cfgWrite(6'h20 + 6'(i), hAddr(i));
    cfgWrite(6'h02, DFLT);
    expectState("R11", 0, 0, 0);
  endtask

  task automatic testMasked();
    pulse(2);
    expectState("R3 disabled", 0, 0, 0);
    cfgWrite(6'h00, 32'hFF);
    expectState("R3 R10 enabled", 1, 0, 2);
    ack(2);
    expectState("R6 ack2", 0, 0, 0);
  endtask

  task automatic testPriority();
    cfgWrite(6'h11, 32'd3);
    cfgWrite(6'h15, 32'd9);
    pulse(1); pulse(5);
    expectState("R4 high wins", 1, 0, 5);
    ack(5);
    expectState("R4 runner-up", 1, 0, 1);
    ack(1);
    expectState("R4 cleared", 0, 0, 0);
  endtask

  task automatic testTie();
    cfgWrite(6'h13, 32'd9);
    pulse(5); pulse(3);
    expectState("R5 tie low index", 1, 0, 3);
    ack(3); ack(5);
    expectState("R5 cleared", 0, 0, 0);
  endtask

  task automatic testHold();
    pulse(4);
    repeat (20) @(negedge clk);
    expectState("R6 no ack holds", 1, 0, 4);
    ack(4);
    expectState("R6 after ack", 0, 0, 0);
  endtask

  task automatic testDrop();
    pulse(6); pulse(6);
    expectState("R7 pending", 1, 0, 6);
    ack(6);
    expectState("R7 single ack clears", 0, 0, 0);
  endtask

  task automatic testFast();
    cfgWrite(6'h01, 32'h80);
    cfgWrite(6'h17, 32'd0);
    pulse(7);
    expectState("R8 fast line", 0, 1, 7);
    pulse(5);
    expectState("R9 fast outranks", 1, 1, 7);
    ack(7);
    expectState("R9 normal after fast", 1, 0, 5);
    ack(5);
    expectState("R9 cleared", 0, 0, 0);
  endtask

  task automatic testEdge();
    reqIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    check(!irqReq, "R2 not after two edges", 32'(irqReq), 0);
    @(negedge clk);
    expectState("R2 after three edges", 1, 0, 0);
    ack(0);
    repeat (10) @(negedge clk);
    expectState("R2 held level once", 0, 0, 0);
    reqIn[0] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testCollide();
    pulse(2);
    reqIn[2] = 1'b1;
    repeat (2) @(negedge clk);
    ack(2);
    expectState("R12 set wins", 1, 0, 2);
    reqIn[2] = 1'b0;
    repeat (3) @(negedge clk);
    ack(2);
    expectState("R12 later ack", 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testConfigIdle();
    testMasked();
    testPriority();
    testTie();
    testHold();
    testDrop();
    testFast();
    testEdge();
    testCollide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule